// File: doc/BRIEF.md
# Write-Through Store Buffer Queue

This block sits between a write-through cache and main memory and holds stores that are still on their way to memory. The processor side offers one store per cycle as an address and a data word; the block accepts it unless every slot is taken. In that case the processor stalls and offers the same store again. The memory side sees the oldest pending store at its head. It retires that store by asserting an acknowledge, at whatever rate memory can take writes.

A read miss in the cache must not return stale memory data while a store to the same address is still queued. For this, the block has a lookup port. It compares a read address against every pending entry in the same cycle. It returns the data of the most recently queued match, which is the value memory will finally hold. The block also keeps a record of the highest occupancy reached since reset, so that a system can see how close the queue came to saturation.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the queue is empty: `occupancy` and `peak_occ` are 0, and `mem_valid`, `st_full` and `lk_hit` are 0.
- R2: A store offered with `st_valid` while the queue is not full is accepted (`st_accept`=1) and appended at the tail, so `occupancy` rises by one in the next cycle unless an entry is retired in the same cycle.
- R3: With DEPTH entries pending, `st_full` is 1. A store offered without `mem_ack` then has `st_accept`=0, and the pending contents and `occupancy` stay unchanged.
- R4: When the queue is full and `mem_ack` and `st_valid` are both high, the head is retired and the new store is accepted in the same cycle, so `occupancy` stays at DEPTH.
- R5: `mem_valid` is 1 exactly when at least one entry is pending. `mem_addr`/`mem_data` show the oldest pending entry, and entries leave strictly in the order they arrived.
- R6: An entry is removed only in a cycle with `mem_ack`=1 while `mem_valid`=1. `mem_ack` on an empty queue has no effect, and a pending head without `mem_ack` stays put.
- R7: `lk_hit` is 1 in the same cycle when `lk_addr` equals the address of any pending entry. `lk_data` then carries the data of the most recently accepted such entry.
- R8: When no pending entry matches `lk_addr`, `lk_hit` is 0 and `lk_data` is all zeros.
- R9: `peak_occ` equals the largest `occupancy` seen since reset. It never decreases and is never below `occupancy`.
- R10: A store accepted while the queue is neither empty nor full, in the same cycle as a retirement, leaves `occupancy` unchanged. The new store lands at the tail behind the remaining entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store this cycle |
| st_addr | input | ADDR_W (32) | Store address |
| st_data | input | DATA_W (32) | Store data word |
| st_accept | output | 1 | The offered store is taken at this clock edge |
| st_full | output | 1 | All slots occupied; processor must hold its store |
| mem_valid | output | 1 | A pending entry is at the head |
| mem_addr | output | ADDR_W (32) | Address of the oldest pending entry |
| mem_data | output | DATA_W (32) | Data of the oldest pending entry |
| mem_ack | input | 1 | Memory takes the head entry at this clock edge |
| lk_addr | input | ADDR_W (32) | Read-miss address to search for |
| lk_hit | output | 1 | Some pending entry matches `lk_addr` |
| lk_data | output | DATA_W (32) | Data of the youngest matching entry, zero on a miss |
| occupancy | output | CNT_W (3) | Number of pending entries |
| peak_occ | output | CNT_W (3) | Highest occupancy since reset |

## Verification
Accepting a store and retiring the head can fall in the same clock edge. This matters most when the queue is full, where acceptance depends on the retirement happening, and in the half-full case, where occupancy must hold still. Directed steps fill the queue, then hold `st_valid` and `mem_ack` together, both at full and at partial occupancy. A long pseudo-random stretch with frequent acknowledges then keeps provoking the overlap. Each cycle, a queue model in the bench predicts acceptance, the head, the count and the lookup result before the edge, and compares them to the ports. The lookup is exercised with a four-address pool, so that duplicate pending addresses are common and youngest-match selection is tested.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  // Slot that holds the entry 'age' places behind the head, on a ring of 'depth' slots.
  function automatic int slot_at_age(int head, int age, int depth);
    return (head + age) % depth;
  endfunction

  // Occupancy after one edge with the given push/pop events.
  function automatic int occ_after(int occ, bit push, bit pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // High-water mark update.
  function automatic int hwm_after(int peak, int occ);
    return (occ > peak) ? occ : peak;
  endfunction

endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] peak
);
  import sdq_pkg::*;

  logic [CNT_W-1:0] count_nx;

  always_comb begin
    count_nx = CNT_W'(occ_after(int'(count), push, pop));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      peak   <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(slot_at_age(int'(wr_ptr), 1, DEPTH));
      if (pop)  rd_ptr <= PTR_W'(slot_at_age(int'(rd_ptr), 1, DEPTH));
      count <= count_nx;
      peak  <= CNT_W'(hwm_after(int'(peak), int'(count_nx)));
    end
  end

endmodule

// File: rtl/sdq_store.sv
module sdq_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_ptr,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [PTR_W-1:0]              rd_ptr,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]  ent_data
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (int'(wr_ptr) == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_addr[i] <= '0;
        ent_data[i] <= '0;
      end else if (sel) begin
        ent_addr[i] <= wr_addr;
        ent_data[i] <= wr_data;
      end
    end
  end

  assign head_addr = ent_addr[rd_ptr];
  assign head_data = ent_data[rd_ptr];

endmodule

// File: rtl/sdq_match.sv
module sdq_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [PTR_W-1:0]             rd_ptr,
  input  logic [CNT_W-1:0]             count,
  input  logic [ADDR_W-1:0]            key,
  output logic                         hit,
  output logic [DATA_W-1:0]            data
);
  import sdq_pkg::*;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    int slot;
    hit  = 1'b0;
    data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = slot_at_age(int'(rd_ptr), k, DEPTH);
      if ((k < int'(count)) && (ent_addr[slot] == key)) begin
        hit  = 1'b1;
        data = ent_data[slot];
      end
    end
  end

endmodule

// File: rtl/store_drain_queue.sv
module store_drain_queue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_accept,
  output logic              st_full,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic [CNT_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  peak_occ
);

  logic [PTR_W-1:0]             wr_ptr, rd_ptr;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;

  // Named internal events, also watched by the checker.
  logic full_w, empty_w, push_evt, pop_evt;

  assign full_w   = (int'(occupancy) == DEPTH);
  assign empty_w  = (occupancy == '0);
  assign pop_evt  = mem_ack && !empty_w;
  assign push_evt = st_valid && (!full_w || pop_evt);

  assign st_accept = push_evt;
  assign st_full   = full_w;
  assign mem_valid = !empty_w;

  sdq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_evt),
    .pop    (pop_evt),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .count  (occupancy),
    .peak   (peak_occ)
  );

  sdq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push_evt),
    .wr_ptr    (wr_ptr),
    .wr_addr   (st_addr),
    .wr_data   (st_data),
    .rd_ptr    (rd_ptr),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  sdq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .PTR_W(PTR_W), .CNT_W(CNT_W)) u_match (
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .rd_ptr   (rd_ptr),
    .count    (occupancy),
    .key      (lk_addr),
    .hit      (lk_hit),
    .data     (lk_data)
  );

endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_full,
  input logic              st_accept,
  input logic              mem_valid,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              lk_hit,
  input logic [CNT_W-1:0]  occupancy,
  input logic [CNT_W-1:0]  peak_occ,
  input logic              push_evt,
  input logic              pop_evt
);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && !mem_ack) |=> (occupancy == $past(occupancy)));

  // R3
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && !mem_ack) |-> !st_accept);

  // R4
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && mem_ack && st_valid) |=> (int'(occupancy) == DEPTH));

  // R6
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && !st_accept) |=> (occupancy == '0));

  // R6
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_data)));

  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !pop_evt) |=> (occupancy == $past(occupancy) + 1'b1));

  // R10
  swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && pop_evt) |=> $stable(occupancy));

  // R9
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (peak_occ >= $past(peak_occ)));

  // R9
  peak_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_occ >= occupancy);

  // R7
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> mem_valid);

  // R5
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid == (occupancy != '0));

endmodule

bind store_drain_queue sdq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_sdq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_full   (st_full),
  .st_accept (st_accept),
  .mem_valid (mem_valid),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .lk_hit    (lk_hit),
  .occupancy (occupancy),
  .peak_occ  (peak_occ),
  .push_evt  (push_evt),
  .pop_evt   (pop_evt)
);

// File: tb/tb_store_drain_queue.sv
`timescale 1ns/1ps
module tb_store_drain_queue;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEP = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_accept, st_full, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ack;
  logic [AW-1:0] lk_addr;
  logic          lk_hit;
  logic [DW-1:0] lk_data;
  logic [CW-1:0] occupancy, peak_occ;

  always #2.5 clk = ~clk;

  store_drain_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_accept(st_accept), .st_full(st_full),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ack(mem_ack),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .occupancy(occupancy), .peak_occ(peak_occ)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural model: plain queues of pending stores.
  logic [AW-1:0] mq_addr[$];
  logic [DW-1:0] mq_data[$];
  int            m_peak = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, compare the ports against the model, then
  // advance the model by the edge that follows.
  task automatic step(bit v, logic [AW-1:0] a, logic [DW-1:0] d, bit ack,
                      logic [AW-1:0] la, string tag);
    bit            e_full, e_acc, e_hit, e_pop;
    logic [DW-1:0] e_ld;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d; mem_ack = ack; lk_addr = la;
    #1;
    e_full = (mq_addr.size() == DEP);
    e_pop  = ack && (mq_addr.size() > 0);
    e_acc  = v && (!e_full || e_pop);
    e_hit  = 1'b0;
    e_ld   = '0;
    foreach (mq_addr[i]) if (mq_addr[i] == la) begin e_hit = 1'b1; e_ld = mq_data[i]; end

    check(st_full == e_full, (tag == "R4") ? "R4" : "R3", "st_full", st_full, e_full);
    check(st_accept == e_acc, (e_full && ack) ? "R4" : "R2", "st_accept", st_accept, e_acc);
    check(mem_valid == (mq_addr.size() > 0), "R5", "mem_valid", mem_valid, mq_addr.size() > 0);
    if (mq_addr.size() > 0) begin
      check(mem_addr == mq_addr[0], "R5", "mem_addr", mem_addr, mq_addr[0]);
      check(mem_data == mq_data[0], "R5", "mem_data", mem_data, mq_data[0]);
    end
    check(lk_hit == e_hit, e_hit ? "R7" : "R8", "lk_hit", lk_hit, e_hit);
    check(lk_data == e_ld, e_hit ? "R7" : "R8", "lk_data", lk_data, e_ld);
    check(int'(occupancy) == mq_addr.size(), tag, "occupancy", occupancy, mq_addr.size());
    check(int'(peak_occ) == m_peak, "R9", "peak_occ", peak_occ, m_peak);

    if (e_pop) begin void'(mq_addr.pop_front()); void'(mq_data.pop_front()); end
    if (e_acc) begin mq_addr.push_back(a); mq_data.push_back(d); end
    if (mq_addr.size() > m_peak) m_peak = mq_addr.size();
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 0; st_addr = '0; st_data = '0; mem_ack = 0; lk_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step(0, 32'h0, 32'h0, 0, 32'h0, "R1");
    // R6: ack on empty queue ignored
    step(0, 32'h0, 32'h0, 1, 32'h100, "R6");
    // R6: store into empty queue with ack in same cycle; ack has nothing to retire
    step(1, 32'h100, 32'hA1, 1, 32'h100, "R6");
    // R2: fill
    step(1, 32'h104, 32'hB2, 0, 32'h100, "R2");
    // R7: one match pending
    step(1, 32'h100, 32'hC3, 0, 32'h100, "R7");
    // R7: two matches pending -> youngest data
    step(1, 32'h108, 32'hD4, 0, 32'h100, "R7");
    // R3: full, store without ack rejected
    step(1, 32'h10C, 32'hE5, 0, 32'h104, "R3");
    // R8: miss
    step(0, 32'h0, 32'h0, 0, 32'h200, "R8");
    // R4: full, store and ack together
    step(1, 32'h110, 32'hF6, 1, 32'h100, "R4");
    step(1, 32'h100, 32'h17, 1, 32'h100, "R4");
    // R5: drain in order
    step(0, 32'h0, 32'h0, 1, 32'h110, "R5");
    step(0, 32'h0, 32'h0, 1, 32'h110, "R5");
    // R10: store and retire while partially filled
    step(1, 32'h120, 32'h28, 1, 32'h120, "R10");
    // R6: head held without ack
    step(0, 32'h0, 32'h0, 0, 32'h120, "R6");
    step(0, 32'h0, 32'h0, 0, 32'h120, "R6");
    // R5: drain to empty
    for (int k = 0; k < 4; k++) step(0, 32'h0, 32'h0, 1, 32'h100, "R5");
    // R9: peak holds after draining
    step(0, 32'h0, 32'h0, 0, 32'h0, "R9");

    // Pseudo-random traffic over a small address pool
    for (int k = 0; k < 3000; k++) begin
      bit            v, ack;
      logic [AW-1:0] a, la;
      v   = ($urandom % 3) != 0;
      ack = ($urandom % 2) != 0;
      a   = 32'h1000 + 32'(($urandom % 4) * 4);
      la  = 32'h1000 + 32'(($urandom % 5) * 4);
      step(v, a, 32'($urandom), ack, la, (v && ack) ? "R10" : "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule